// File: doc/BRIEF.md
# Bus Transfer Record Monitor

This block sits beside a cache and watches two streams: the demand references that the processor side presents (data reads, data writes, instruction fetches and other accesses), and the transfers that the cache makes on its memory bus (reads, write-backs, prefetches and clean replacements). For every bus transfer it produces one record. A record carries the transfer kind, its size in bytes, its byte address, and two counts: how many demand references were taken since the previous bus transfer, and how many of those were instruction fetches. The counts restart after every bus transfer. Records are compact binary fields; turning them into text happens elsewhere.

A mode input turns on snoop records. These report clean sub-blocks that the cache replaced without any bus traffic. A snoop record shows the counts as they stand, but it is not a bus transfer, so it does not restart them. When the mode is off, clean replacements are accepted and leave no trace.

The monitor also gates the reference stream. A programmable number of leading references is discarded. After that, at most a programmable number of references is taken. When that limit is zero, a parameter default of ten million applies. Once the window is used up, further references are accepted but not counted. Transfers the cache makes on its own, such as prefetches, arrive on the transfer side and never count toward the limit. Records leave on a valid/ready interface. While a record waits on a stalled consumer, both input streams are held.

Top module: `bus_xfer_recorder`

## Requirements
- R1: After reset, rec_valid is 0, limit_reached is 0, and both since-transfer counts are 0.
- R2: An accepted transfer of kind 0 (bus read), 1 (bus write) or 2 (bus prefetch) produces a record in the next cycle. The record has the same kind code and carries xfer_size and xfer_addr unchanged.
- R3: rec_refs equals the number of references taken (ref_taken high) since the last record of kind 0, 1 or 2. rec_ifetch counts those with ref_kind 2 (instruction fetch). rec_ifetch never exceeds rec_refs.
- R4: A record of kind 0, 1 or 2 restarts both counts. A reference taken in the same cycle as that transfer is counted toward the next record, not the one being emitted.
- R5: Each count saturates at 2^CNT_W-1 instead of wrapping.
- R6: With snoop_en=1, a transfer of kind 3 (clean replacement) produces a record of kind 3 carrying the current counts and does not restart them. With snoop_en=0, such a transfer is accepted, produces no record and leaves the counts unchanged.
- R7: The first cfg_skip_count accepted references are discarded: ref_taken stays 0 for them and they are not counted.
- R8: After the skipped references, at most L references are taken. L is cfg_max_count, or DEFAULT_LIMIT when cfg_max_count is 0. Once L references have been taken, limit_reached is 1 and ref_taken stays 0.
- R9: While rec_valid=1 and rec_ready=0, xfer_ready and ref_ready are 0 and every record field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_en | input | 1 | Enables records for clean replacements |
| cfg_skip_count | input | LIMIT_W | Number of leading references to discard |
| cfg_max_count | input | LIMIT_W | Reference limit after skipping; 0 selects DEFAULT_LIMIT |
| ref_valid | input | 1 | Demand reference present |
| ref_ready | output | 1 | Reference accepted this cycle when valid |
| ref_kind | input | 2 | 0 data read, 1 data write, 2 instruction fetch, 3 other |
| ref_taken | output | 1 | Accepted reference lies inside the skip/limit window |
| limit_reached | output | 1 | Reference limit used up |
| xfer_valid | input | 1 | Bus transfer or clean replacement present |
| xfer_ready | output | 1 | Transfer accepted this cycle when valid |
| xfer_kind | input | 2 | 0 read, 1 write, 2 prefetch, 3 clean replacement |
| xfer_size | input | SIZE_W | Transfer size in bytes |
| xfer_addr | input | ADDR_W | Transfer byte address |
| rec_valid | output | 1 | Record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_kind | output | 2 | Record kind code, same encoding as xfer_kind |
| rec_size | output | SIZE_W | Transfer size |
| rec_addr | output | ADDR_W | Transfer address |
| rec_refs | output | CNT_W | Demand references since the last bus transfer |
| rec_ifetch | output | CNT_W | Instruction fetches since the last bus transfer |

## Verification
The assertions check on every cycle that a stalled record holds still and blocks both inputs. They also check that a dropped clean replacement leaves no record, that the counts fall to at most one after a restart, that a saturated count stays pinned, that no reference is taken after the limit, and that a record never reports more instruction fetches than references. Only the bench's scenarios can show that the counts are correct: that snoop records leave them running, that a same-cycle reference lands in the next record, and that the skip and limit window lines up with the exact reference numbers, including the default limit.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  typedef enum logic [1:0] {
    XK_READ     = 2'd0,
    XK_WRITE    = 2'd1,
    XK_PREFETCH = 2'd2,
    XK_SNOOP    = 2'd3
  } xfer_kind_e;

  localparam logic [1:0] RK_IFETCH = 2'd2;

  // Saturating increment on a value whose ceiling is passed in.
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] top);
    return (v >= top) ? top : v + 32'd1;
  endfunction

  // Zero-valued limit selects the default.
  function automatic logic [31:0] eff_limit(input logic [31:0] cfg, input logic [31:0] dflt);
    return (cfg == 32'd0) ? dflt : cfg;
  endfunction

  // A transfer restarts the counts unless it is a clean replacement.
  function automatic logic restarts_counts(input logic [1:0] kind);
    return kind != XK_SNOOP;
  endfunction

  // A transfer produces a record unless it is a suppressed clean replacement.
  function automatic logic makes_record(input logic [1:0] kind, input logic snoop_on);
    return (kind != XK_SNOOP) || snoop_on;
  endfunction

endpackage

// File: rtl/bxr_ref_gate.sv
module bxr_ref_gate #(
  parameter int LIMIT_W       = 32,
  parameter int DEFAULT_LIMIT = 10_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LIMIT_W-1:0] cfg_skip_count,
  input  logic [LIMIT_W-1:0] cfg_max_count,
  input  logic               ref_fire,
  output logic               ref_taken,
  output logic               limit_reached
);
  import bxr_pkg::*;

  localparam logic [LIMIT_W-1:0] DFLT = LIMIT_W'(DEFAULT_LIMIT);

  logic [LIMIT_W-1:0] skipped_q, processed_q, limit;
  logic               skipping;

  always_comb begin
    limit         = LIMIT_W'(eff_limit(32'(cfg_max_count), 32'(DFLT)));
    skipping      = skipped_q < cfg_skip_count;
    limit_reached = !skipping && (processed_q >= limit);
    ref_taken     = ref_fire && !skipping && !limit_reached;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skipped_q   <= '0;
      processed_q <= '0;
    end else begin
      if (ref_fire && skipping) skipped_q <= skipped_q + 1'b1;
      if (ref_taken)            processed_q <= processed_q + 1'b1;
    end
  end

endmodule

// File: rtl/bxr_since_cnt.sv
module bxr_since_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  import bxr_pkg::*;

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (restart)
      count_q <= bump ? CNT_W'(1) : '0;
    else if (bump)
      count_q <= CNT_W'(sat_step(32'(count_q), 32'(TOP)));
  end

  assign count = count_q;

endmodule

// File: rtl/bxr_rec_stage.sv
module bxr_rec_stage #(
  parameter int SIZE_W = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        in_kind,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CNT_W-1:0]  in_refs,
  input  logic [CNT_W-1:0]  in_ifetch,
  output logic              space,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [1:0]        rec_kind,
  output logic [SIZE_W-1:0] rec_size,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [CNT_W-1:0]  rec_refs,
  output logic [CNT_W-1:0]  rec_ifetch
);

  assign space = !rec_valid || rec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid  <= 1'b0;
      rec_kind   <= 2'd0;
      rec_size   <= '0;
      rec_addr   <= '0;
      rec_refs   <= '0;
      rec_ifetch <= '0;
    end else if (load) begin
      rec_valid  <= 1'b1;
      rec_kind   <= in_kind;
      rec_size   <= in_size;
      rec_addr   <= in_addr;
      rec_refs   <= in_refs;
      rec_ifetch <= in_ifetch;
    end else if (rec_ready) begin
      rec_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_xfer_recorder.sv
module bus_xfer_recorder #(
  parameter int SIZE_W        = 8,
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 16,
  parameter int LIMIT_W       = 32,
  parameter int DEFAULT_LIMIT = 10_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snoop_en,
  input  logic [LIMIT_W-1:0] cfg_skip_count,
  input  logic [LIMIT_W-1:0] cfg_max_count,
  input  logic               ref_valid,
  output logic               ref_ready,
  input  logic [1:0]         ref_kind,
  output logic               ref_taken,
  output logic               limit_reached,
  input  logic               xfer_valid,
  output logic               xfer_ready,
  input  logic [1:0]         xfer_kind,
  input  logic [SIZE_W-1:0]  xfer_size,
  input  logic [ADDR_W-1:0]  xfer_addr,
  output logic               rec_valid,
  input  logic               rec_ready,
  output logic [1:0]         rec_kind,
  output logic [SIZE_W-1:0]  rec_size,
  output logic [ADDR_W-1:0]  rec_addr,
  output logic [CNT_W-1:0]   rec_refs,
  output logic [CNT_W-1:0]   rec_ifetch
);
  import bxr_pkg::*;

  // Named internal events, visible to the bound checker.
  logic             space;
  logic             ref_fire;
  logic             xfer_fire;
  logic             cnt_clr;
  logic             rec_load;
  logic             ifetch_hit;
  logic [CNT_W-1:0] refs_cnt;
  logic [CNT_W-1:0] ifetch_cnt;

  assign ref_ready  = space;
  assign xfer_ready = space;
  assign ref_fire   = ref_valid && space;
  assign xfer_fire  = xfer_valid && space;
  assign cnt_clr    = xfer_fire && restarts_counts(xfer_kind);
  assign rec_load   = xfer_fire && makes_record(xfer_kind, snoop_en);
  assign ifetch_hit = ref_taken && (ref_kind == RK_IFETCH);

  bxr_ref_gate #(
    .LIMIT_W      (LIMIT_W),
    .DEFAULT_LIMIT(DEFAULT_LIMIT)
  ) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_skip_count(cfg_skip_count),
    .cfg_max_count (cfg_max_count),
    .ref_fire      (ref_fire),
    .ref_taken     (ref_taken),
    .limit_reached (limit_reached)
  );

  bxr_since_cnt #(.CNT_W(CNT_W)) u_refs (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cnt_clr),
    .bump   (ref_taken),
    .count  (refs_cnt)
  );

  bxr_since_cnt #(.CNT_W(CNT_W)) u_ifetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cnt_clr),
    .bump   (ifetch_hit),
    .count  (ifetch_cnt)
  );

  bxr_rec_stage #(
    .SIZE_W(SIZE_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rec_load),
    .in_kind   (xfer_kind),
    .in_size   (xfer_size),
    .in_addr   (xfer_addr),
    .in_refs   (refs_cnt),
    .in_ifetch (ifetch_cnt),
    .space     (space),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_kind  (rec_kind),
    .rec_size  (rec_size),
    .rec_addr  (rec_addr),
    .rec_refs  (rec_refs),
    .rec_ifetch(rec_ifetch)
  );

endmodule

// File: rtl/bus_xfer_recorder_chk.sv
module bus_xfer_recorder_chk #(
  parameter int SIZE_W = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              snoop_en,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [1:0]        xfer_kind,
  input logic              ref_ready,
  input logic              ref_taken,
  input logic              limit_reached,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [1:0]        rec_kind,
  input logic [SIZE_W-1:0] rec_size,
  input logic [ADDR_W-1:0] rec_addr,
  input logic [CNT_W-1:0]  rec_refs,
  input logic [CNT_W-1:0]  rec_ifetch,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  refs_cnt
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (!rec_valid && refs_cnt == '0));

  assert_ifetch_within_refs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_ifetch <= rec_refs));

  assert_restart_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (refs_cnt <= CNT_W'(1)));

  assert_saturate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && refs_cnt == '1) |=> (refs_cnt == '1));

  assert_snoop_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_kind == 2'd3 && !snoop_en && !rec_valid) |=> !rec_valid);

  assert_no_take_past_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    limit_reached |-> !ref_taken);

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |-> (!xfer_ready && !ref_ready));

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_addr) && $stable(rec_kind)
                                   && $stable(rec_size) && $stable(rec_refs)));

endmodule

bind bus_xfer_recorder bus_xfer_recorder_chk #(
  .SIZE_W(SIZE_W),
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snoop_en     (snoop_en),
  .xfer_valid   (xfer_valid),
  .xfer_ready   (xfer_ready),
  .xfer_kind    (xfer_kind),
  .ref_ready    (ref_ready),
  .ref_taken    (ref_taken),
  .limit_reached(limit_reached),
  .rec_valid    (rec_valid),
  .rec_ready    (rec_ready),
  .rec_kind     (rec_kind),
  .rec_size     (rec_size),
  .rec_addr     (rec_addr),
  .rec_refs     (rec_refs),
  .rec_ifetch   (rec_ifetch),
  .cnt_clr      (cnt_clr),
  .refs_cnt     (refs_cnt)
);

// File: tb/bus_xfer_recorder_test.sv
`timescale 1ns/1ps
module bus_xfer_recorder_test;

  localparam int SIZE_W = 8;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 4;
  localparam int LIMIT_W = 32;
  localparam int DLIM   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snoop_en = 1'b0;
  logic [LIMIT_W-1:0] cfg_skip_count = '0;
  logic [LIMIT_W-1:0] cfg_max_count = '0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic [1:0] ref_kind = 2'd0;
  logic ref_taken, limit_reached;
  logic xfer_valid = 1'b0;
  logic xfer_ready;
  logic [1:0] xfer_kind = 2'd0;
  logic [SIZE_W-1:0] xfer_size = '0;
  logic [ADDR_W-1:0] xfer_addr = '0;
  logic rec_valid;
  logic rec_ready = 1'b1;
  logic [1:0] rec_kind;
  logic [SIZE_W-1:0] rec_size;
  logic [ADDR_W-1:0] rec_addr;
  logic [CNT_W-1:0] rec_refs, rec_ifetch;

  always #4 clk = ~clk;

  bus_xfer_recorder #(
    .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .LIMIT_W(LIMIT_W), .DEFAULT_LIMIT(DLIM)
  ) uut (
    .clk(clk), .rst_n(rst_n), .snoop_en(snoop_en),
    .cfg_skip_count(cfg_skip_count), .cfg_max_count(cfg_max_count),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_kind(ref_kind),
    .ref_taken(ref_taken), .limit_reached(limit_reached),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_kind(xfer_kind),
    .xfer_size(xfer_size), .xfer_addr(xfer_addr),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_kind(rec_kind),
    .rec_size(rec_size), .rec_addr(rec_addr), .rec_refs(rec_refs),
    .rec_ifetch(rec_ifetch)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One reference; returns ref_taken seen during its cycle.
  task automatic send_ref(input logic [1:0] k, output logic taken);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_kind  = k;
    #1 taken = ref_taken;
    @(posedge clk);
    #1 ref_valid = 1'b0;
  endtask

  // One transfer; afterwards the clock is at the negedge following acceptance.
  task automatic send_xfer(input logic [1:0] k, input logic [SIZE_W-1:0] sz,
                           input logic [ADDR_W-1:0] a);
    @(negedge clk);
    xfer_valid = 1'b1;
    xfer_kind  = k;
    xfer_size  = sz;
    xfer_addr  = a;
    @(posedge clk);
    #1 xfer_valid = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0] n_rd;
    logic [7:0] n_if;
    logic [1:0] xk;
    logic       snp;
    logic       exp_rec;
    logic [7:0] exp_refs;
    logic [7:0] exp_if;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  8'd1, 2'd0, 1'b1, 1'b1, 8'd3,  8'd1},  // R2 R3 read
    '{8'd0,  8'd0, 2'd1, 1'b1, 1'b1, 8'd0,  8'd0},  // R2 R4 write right after restart
    '{8'd1,  8'd2, 2'd3, 1'b1, 1'b1, 8'd3,  8'd2},  // R6 snoop, no restart
    '{8'd1,  8'd0, 2'd2, 1'b1, 1'b1, 8'd4,  8'd2},  // R2 R6 prefetch sees running counts
    '{8'd2,  8'd0, 2'd3, 1'b0, 1'b0, 8'd0,  8'd0},  // R6 snoop suppressed
    '{8'd0,  8'd1, 2'd1, 1'b1, 1'b1, 8'd3,  8'd1},  // R6 suppressed snoop left counts
    '{8'd20, 8'd0, 2'd0, 1'b1, 1'b1, 8'd15, 8'd0}   // R5 saturation at 15
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic t;
    int taken_n;

    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 rec_valid", 32'(rec_valid), 32'd0);
    check("R1 limit_reached", 32'(limit_reached), 32'd0);
    send_xfer(2'd1, 8'd4, 32'h0);
    check("R1 counts zero refs", 32'(rec_refs), 32'd0);
    check("R1 counts zero ifetch", 32'(rec_ifetch), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      snoop_en = VECS[i].snp;
      for (int j = 0; j < int'(VECS[i].n_rd); j++) send_ref(2'd0, t);
      for (int j = 0; j < int'(VECS[i].n_if); j++) send_ref(2'd2, t);
      send_xfer(VECS[i].xk, 8'(16 + i), 32'h1000 + 32'(i * 16));
      check("R2 R6 record presence", 32'(rec_valid), 32'(VECS[i].exp_rec));
      if (VECS[i].exp_rec) begin
        check("R2 kind", 32'(rec_kind), 32'(VECS[i].xk));
        check("R2 size", 32'(rec_size), 32'(16 + i));
        check("R2 addr", rec_addr, 32'h1000 + 32'(i * 16));
        check("R3 R5 refs", 32'(rec_refs), 32'(VECS[i].exp_refs));
        check("R3 ifetch", 32'(rec_ifetch), 32'(VECS[i].exp_if));
      end
    end
    snoop_en = 1'b1;

    // R4 same-cycle reference goes to the next record
    send_ref(2'd0, t);
    send_ref(2'd0, t);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_kind = 2'd0; xfer_addr = 32'h2000;
    ref_valid = 1'b1; ref_kind = 2'd2;
    @(posedge clk);
    #1 xfer_valid = 1'b0; ref_valid = 1'b0;
    @(negedge clk);
    check("R4 record before same-cycle ref", 32'(rec_refs), 32'd2);
    check("R4 ifetch before same-cycle ref", 32'(rec_ifetch), 32'd0);
    send_xfer(2'd1, 8'd8, 32'h2040);
    check("R4 same-cycle ref in next refs", 32'(rec_refs), 32'd1);
    check("R4 same-cycle ref in next ifetch", 32'(rec_ifetch), 32'd1);

    // R9 stall holds record and blocks inputs
    @(negedge clk);
    rec_ready = 1'b0;
    send_xfer(2'd2, 8'd32, 32'h3000);
    repeat (3) @(negedge clk);
    check("R9 still valid", 32'(rec_valid), 32'd1);
    check("R9 addr held", rec_addr, 32'h3000);
    check("R9 xfer_ready low", 32'(xfer_ready), 32'd0);
    check("R9 ref_ready low", 32'(ref_ready), 32'd0);
    rec_ready = 1'b1;
    @(negedge clk);
    check("R9 released", 32'(rec_valid), 32'd0);

    // R7 R8 skip three, then take two
    cfg_skip_count = 32'd3;
    cfg_max_count  = 32'd2;
    do_reset();
    for (int j = 0; j < 6; j++) begin
      send_ref(2'd0, t);
      check((j < 3) ? "R7 skipped ref" : "R8 window ref", 32'(t),
            (j == 3 || j == 4) ? 32'd1 : 32'd0);
    end
    @(negedge clk);
    check("R8 limit_reached", 32'(limit_reached), 32'd1);
    send_xfer(2'd0, 8'd4, 32'h4000);
    check("R7 R8 refs counted", 32'(rec_refs), 32'd2);

    // R8 default limit when max is zero
    cfg_skip_count = 32'd0;
    cfg_max_count  = 32'd0;
    do_reset();
    taken_n = 0;
    for (int j = 0; j < DLIM + 6; j++) begin
      send_ref(2'd1, t);
      if (t) taken_n++;
    end
    check("R8 default limit count", 32'(taken_n), 32'(DLIM));
    @(negedge clk);
    check("R8 default limit flag", 32'(limit_reached), 32'd1);

    summary();
  end

endmodule